// File: doc/BRIEF.md
# Memory-Mapped Parallel I/O Port with Interrupt Capture

This block is a general-purpose parallel I/O port of up to 32 pins, controlled over a small word-addressed register bus. Each pin has an output data bit, a direction bit and an interrupt enable bit. Each pin also has a sticky capture bit that records transitions on the synchronised input. The pad cells sit outside the block: it drives separate output-value and output-enable vectors and reads back a raw input vector.

One interrupt line leaves the block. Its trigger kind is fixed when the block is built, by a parameter, and cannot change at run time. In the three edge kinds, the line is raised while any enabled capture bit is set, and software clears capture bits by writing ones to them. In the level kind, capture is not used: the line follows the synchronised pin state gated by the enable bits.

Top module: `pio_irq_top`

## Requirements
- R1: While reset is held and in the cycle after it, the output data, direction, interrupt-enable and capture registers are all zero, so pin_out, pin_oe and irq are low.
- R2: The two-bit register select bus_addr (byte offset bits 3..2) chooses the register: 0 = pin data, 1 = direction, 2 = interrupt enable, 3 = capture. A write takes effect at the clock edge where bus_wr is high. bus_rdata shows the selected register one clock after bus_addr is presented.
- R3: Bits at and above PIN_COUNT always read as zero, and writes to those bits have no effect.
- R4: pin_oe bit i is the direction bit i (1 = drive, 0 = input). pin_out follows the last value written to the data register, and keeps that value while the pin is an input.
- R5: Reading the data register returns the pin input state after a SYNC_STAGES-deep synchroniser, not the stored output value.
- R6: The capture bit of a pin is set by a synchronised transition of the kind chosen by TRIGGER (0 = low-to-high, 1 = high-to-low, 2 = either). It stays set until cleared, whatever the interrupt-enable bit is.
- R7: Writing to the capture register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: If a new transition and a clearing write hit the same capture bit at the same edge, the bit stays set. Other bits in the same write are still cleared.
- R9: In the edge kinds (TRIGGER 0 to 2), irq is registered and equals the OR over pins of capture AND enable, one clock after those registers change.
- R10: In the level kind (TRIGGER = 3), the capture register stays zero and irq is the registered OR over pins of the synchronised input AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select (word index) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | PIN_COUNT | Raw pin input state |
| pin_out | output | PIN_COUNT | Output value towards the pads |
| pin_oe | output | PIN_COUNT | Per-pin output enable |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds four copies with PIN_COUNT = 12, one for each TRIGGER value, all sharing one bus and one pin vector. Because the port is narrower than 32 bits, the zeroed upper read bits and the ignored upper write bits can be observed. Having all four trigger kinds side by side lets a single pin pattern show which copies capture a rise, which capture a fall, and how the level copy ignores capture. The same-edge collision between a transition and a clearing write is placed on an exact cycle, counted from the synchroniser depth.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int BUS_W = 32;
  localparam int SEL_W = 2;

  // Trigger kinds, fixed at build time
  localparam int TRIG_RISE  = 0;
  localparam int TRIG_FALL  = 1;
  localparam int TRIG_BOTH  = 2;
  localparam int TRIG_LEVEL = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_CAPT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] synced
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign synced = stage_q[STAGES-1];
endmodule

// File: rtl/pio_edge.sv
module pio_edge
  import pio_pkg::*;
#(
  parameter int W       = 32,
  parameter int TRIGGER = TRIG_RISE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= cur;
  end

  if (TRIGGER == TRIG_RISE) begin : g_rise
    assign hit = cur & ~prev_q;
  end else if (TRIGGER == TRIG_FALL) begin : g_fall
    assign hit = ~cur & prev_q;
  end else begin : g_both
    assign hit = cur ^ prev_q;
  end
endmodule

// File: rtl/pio_capture.sv
module pio_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] hit,
  output logic [W-1:0] cap_q
);
  // A new transition takes priority over a clear on the same bit
  always_ff @(posedge clk) begin
    if (rst) cap_q <= '0;
    else     cap_q <= (cap_q & ~clr) | hit;
  end
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             wr,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     data_q,
  output logic [W-1:0]     dir_q,
  output logic [W-1:0]     mask_q,
  output logic [W-1:0]     capt_clr
);
  reg_sel_e sel_e;
  assign sel_e = reg_sel_e'(sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else if (wr) begin
      case (sel_e)
        SEL_DATA: data_q <= wdata;
        SEL_DIR:  dir_q  <= wdata;
        SEL_MASK: mask_q <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    capt_clr = '0;
    if (wr && sel_e == SEL_CAPT) capt_clr = wdata;
  end
endmodule

// File: rtl/pio_irq_top.sv
module pio_irq_top
  import pio_pkg::*;
#(
  parameter int PIN_COUNT   = 32,
  parameter int TRIGGER     = TRIG_RISE,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SEL_W-1:0]     bus_addr,
  input  logic                 bus_wr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  input  logic [PIN_COUNT-1:0] pin_in,
  output logic [PIN_COUNT-1:0] pin_out,
  output logic [PIN_COUNT-1:0] pin_oe,
  output logic                 irq
);
  localparam bit IS_LEVEL = (TRIGGER == TRIG_LEVEL);

  logic [PIN_COUNT-1:0] synced;
  logic [PIN_COUNT-1:0] edge_hit;
  logic [PIN_COUNT-1:0] cap_q;
  logic [PIN_COUNT-1:0] data_q;
  logic [PIN_COUNT-1:0] dir_q;
  logic [PIN_COUNT-1:0] mask_q;
  logic [PIN_COUNT-1:0] capt_clr;
  logic [PIN_COUNT-1:0] rd_word;
  logic                 irq_d;

  pio_sync #(.W(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw    (pin_in),
    .synced (synced)
  );

  pio_regs #(.W(PIN_COUNT)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .sel      (bus_addr),
    .wr       (bus_wr),
    .wdata    (bus_wdata[PIN_COUNT-1:0]),
    .data_q   (data_q),
    .dir_q    (dir_q),
    .mask_q   (mask_q),
    .capt_clr (capt_clr)
  );

  if (IS_LEVEL) begin : g_level
    assign edge_hit = '0;
    assign irq_d    = |(synced & mask_q);
  end else begin : g_edge
    pio_edge #(.W(PIN_COUNT), .TRIGGER(TRIGGER)) u_edge (
      .clk (clk),
      .rst (rst),
      .cur (synced),
      .hit (edge_hit)
    );
    assign irq_d = |(cap_q & mask_q);
  end

  pio_capture #(.W(PIN_COUNT)) u_capt (
    .clk   (clk),
    .rst   (rst),
    .clr   (capt_clr),
    .hit   (edge_hit),
    .cap_q (cap_q)
  );

  always_comb begin
    case (reg_sel_e'(bus_addr))
      SEL_DATA: rd_word = synced;
      SEL_DIR:  rd_word = dir_q;
      SEL_MASK: rd_word = mask_q;
      default:  rd_word = cap_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= BUS_W'(rd_word);
      irq       <= irq_d;
    end
  end

  assign pin_out = data_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/pio_irq_checker.sv
module pio_irq_checker #(
  parameter int W       = 32,
  parameter int TRIGGER = 0
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   bus_addr,
  input logic         bus_wr,
  input logic [W-1:0] wdata,
  input logic [31:0]  bus_rdata,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe,
  input logic         irq,
  input logic [W-1:0] cap_q,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] edge_hit
);
  // R1: everything quiet in the cycle after reset
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0 && irq == 1'b0 && cap_q == '0 && mask_q == '0));

  // R2: read data never carries unknown bits once out of reset
  a_r2_rdata_known: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(bus_rdata));

  // R4: direction only moves on a direction write
  a_r4_dir_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == 2'd1) |=> $stable(pin_oe));

  // R4: output value only moves on a data write
  a_r4_data_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == 2'd0) |=> $stable(pin_out));

  // R6: capture bits are sticky without a clearing write
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == 2'd3) |=> ((cap_q & $past(cap_q)) == $past(cap_q)));

  // R7: bits written as one and not hit by a transition end up clear
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd3) |=> ((cap_q & $past(wdata) & ~$past(edge_hit)) == '0));

  // R8: a transition always leaves its bit set
  a_r8_edge_wins: assert property (@(posedge clk) disable iff (rst)
    (|edge_hit) |=> ((cap_q & $past(edge_hit)) == $past(edge_hit)));

  if (TRIGGER == 3) begin : g_lvl
    // R10: capture unused in level mode
    a_r10_no_capture: assert property (@(posedge clk) disable iff (rst)
      cap_q == '0);
  end else begin : g_edg
    // R9: interrupt follows enabled capture one clock later
    a_r9_irq_follow: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (irq == $past(|(cap_q & mask_q))));
  end

  if (W < 32) begin : g_upper
    // R3: unused upper bits read as zero
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
      bus_rdata[31:W] == '0);
  end
endmodule

bind pio_irq_top pio_irq_checker #(.W(PIN_COUNT), .TRIGGER(TRIGGER)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .wdata     (bus_wdata[PIN_COUNT-1:0]),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .cap_q     (cap_q),
  .mask_q    (mask_q),
  .edge_hit  (edge_hit)
);

// File: tb/sim_pio_irq_top.sv
module sim_pio_irq_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP         = 12;
  localparam int WATCHDOG   = 5000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [NP-1:0] pin_in = '0;

  logic [31:0]   rdata [4];
  logic [NP-1:0] pout  [4];
  logic [NP-1:0] poe   [4];
  logic [3:0]    irqv;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // u0 rising, u1 falling, u2 both, u3 level
  pio_irq_top #(.PIN_COUNT(NP), .TRIGGER(0)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata[0]), .pin_in(pin_in), .pin_out(pout[0]), .pin_oe(poe[0]), .irq(irqv[0]));
  pio_irq_top #(.PIN_COUNT(NP), .TRIGGER(1)) u1 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata[1]), .pin_in(pin_in), .pin_out(pout[1]), .pin_oe(poe[1]), .irq(irqv[1]));
  pio_irq_top #(.PIN_COUNT(NP), .TRIGGER(2)) u2 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata[2]), .pin_in(pin_in), .pin_out(pout[2]), .pin_oe(poe[2]), .irq(irqv[2]));
  pio_irq_top #(.PIN_COUNT(NP), .TRIGGER(3)) u3 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata[3]), .pin_in(pin_in), .pin_out(pout[3]), .pin_oe(poe[3]), .irq(irqv[3]));

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } rd_item_t;

  rd_item_t exp_q [$];
  logic rd_req  = 1'b0;
  logic rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= rd_req;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compares each registered read result against the queue
  always @(negedge clk) begin
    if (rd_seen && !finished) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected read", 32'd1, 32'd0);
      end else begin
        rd_item_t it;
        it = exp_q.pop_front();
        chk(it.tag, rdata[it.sel], it.exp);
      end
    end
  end

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(logic [1:0] a, logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic do_read(int sel, logic [1:0] a, logic [31:0] e, string tag);
    rd_item_t it;
    it.sel = sel;
    it.exp = e;
    it.tag = tag;
    exp_q.push_back(it);
    bus_addr = a;
    rd_req   = 1'b1;
    @(negedge clk);
    rd_req   = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    settle(3);
    rst = 1'b0;

    // R1 reset state
    chk("R1 pin_oe", 32'(poe[0]), 32'h0);
    chk("R1 pin_out", 32'(pout[0]), 32'h0);
    chk("R1 irq", 32'(irqv), 32'h0);
    do_read(0, 2'd0, 32'h0, "R1 data reg");
    do_read(0, 2'd1, 32'h0, "R1 dir reg");
    do_read(0, 2'd2, 32'h0, "R1 mask reg");
    do_read(0, 2'd3, 32'h0, "R1 capt reg");

    // R2 R3 R4 output value and direction, upper bits dropped
    do_write(2'd0, 32'hFFFF_FA5A);
    chk("R4 pin_out value", 32'(pout[0]), 32'h0000_0A5A);
    do_write(2'd1, 32'hFFFF_F0F0);
    chk("R4 pin_oe value", 32'(poe[0]), 32'h0000_00F0);
    chk("R4 pin_out held on input pins", 32'(pout[0]), 32'h0000_0A5A);
    do_read(0, 2'd1, 32'h0000_00F0, "R3 dir upper bits zero");
    do_read(0, 2'd0, 32'h0, "R5 data reads pins not output reg");
    do_write(2'd2, 32'hFFFF_FFFF);
    do_read(0, 2'd2, 32'h0000_0FFF, "R3 mask upper bits zero");
    do_write(2'd2, 32'h0);

    // R5 R6 rising pattern with interrupts disabled
    pin_in = 12'h3C3;
    settle(5);
    do_read(0, 2'd0, 32'h3C3, "R5 synchronised pin state");
    do_read(0, 2'd3, 32'h3C3, "R6 rise captured");
    do_read(1, 2'd3, 32'h000, "R6 falling kind ignores rise");
    do_read(2, 2'd3, 32'h3C3, "R6 both kind captures rise");
    do_read(3, 2'd3, 32'h000, "R10 level kind capture stays zero");
    chk("R9 masked capture gives no irq", 32'(irqv), 32'h0);

    // R9 R10 enable pin 0
    do_write(2'd2, 32'h001);
    settle(1);
    chk("R9 edge irq rising", 32'(irqv[0]), 32'h1);
    chk("R9 edge irq falling idle", 32'(irqv[1]), 32'h0);
    chk("R9 edge irq both", 32'(irqv[2]), 32'h1);
    chk("R10 level irq high", 32'(irqv[3]), 32'h1);

    // R7 write-one-to-clear
    do_write(2'd3, 32'h0C0);
    do_read(0, 2'd3, 32'h303, "R7 ones clear");
    do_write(2'd3, 32'h000);
    do_read(0, 2'd3, 32'h303, "R7 zeros leave bits");
    do_write(2'd3, 32'h001);
    settle(1);
    chk("R9 irq drops after clear", 32'(irqv[0]), 32'h0);
    chk("R10 level irq ignores capture clear", 32'(irqv[3]), 32'h1);
    do_read(0, 2'd3, 32'h302, "R7 enabled bit cleared");

    // R6 R10 falling pattern
    pin_in = 12'h000;
    settle(5);
    do_read(1, 2'd3, 32'h3C3, "R6 fall captured");
    do_read(2, 2'd3, 32'h3C3, "R6 both kind captures fall");
    do_read(0, 2'd3, 32'h302, "R6 rising kind ignores fall");
    chk("R10 level irq low", 32'(irqv[3]), 32'h0);
    chk("R9 falling kind irq", 32'(irqv[1]), 32'h1);

    // R8 transition and clear on the same edge
    do_write(2'd3, 32'hFFF);
    do_read(0, 2'd3, 32'h000, "R7 clear all");
    pin_in = 12'h003;
    settle(5);
    pin_in = 12'h000;
    settle(5);
    do_read(0, 2'd3, 32'h003, "R8 setup");
    pin_in = 12'h001;
    settle(2);
    do_write(2'd3, 32'h003);
    do_read(0, 2'd3, 32'h001, "R8 new edge wins over clear");

    settle(2);
    finished = 1'b1;
    if (exp_q.size() != 0) chk("R2 reads outstanding", 32'(exp_q.size()), 32'h0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule